// File: doc/BRIEF.md
# Programmable Duty-Cycle Channel Divider

This block divides a fast input clock down to a channel clock whose high time and low time are programmed separately, each as a count of input-clock cycles. The block can pass the input clock straight to the output, and it can drive the output to a static high level. A shared synchronization strobe, which the channel may be told to ignore, restarts the divider at a chosen starting level. The first phase after a restart can be stretched by a phase offset, so that several channels fed by the same strobe keep a fixed skew between them.

Configuration arrives as two bytes through a small write port and is held in shadow registers. The shadow registers are copied into the working registers only while the strobe is being obeyed, while the divider is idle (bypassed or forced), or at the end of a full output period. This way a reprogramming never cuts a phase short.

Top module: `chan_div`

## Requirements
- R1: In the timing byte (`cfg_sel`=0), bits [7:4] hold the low field; the output stays low for (low field + 1) input cycles, so a value of 0 gives one cycle low.
- R2: In the timing byte, bits [3:0] hold the high field; the output stays high for (high field + 1) input cycles, so a value of 0 gives one cycle high.
- R3: The output period is (high + 1) + (low + 1) input cycles. After a restart, the output first runs the phase given by the start-level bit (control byte, `cfg_sel`=1, bit 4: 1 means high first, 0 means low first).
- R4: When the bypass bit (control bit 7) is set, `div_out` follows `clk_in` directly. Bypass takes priority over the force bit.
- R5: When the ignore-strobe bit (control bit 6) is clear, `sync` high holds the output at its start level and resets the counting. Counting resumes from the first edge at which `sync` is low.
- R6: When the ignore-strobe bit is set, `sync` has no effect on the output waveform.
- R7: When the force bit (control bit 5) and the ignore-strobe bit are both set, and bypass is clear, the output is held high. The force bit has no effect when the ignore-strobe bit is clear.
- R8: Control bits [3:0] hold a phase offset P. After a restart, the first phase lasts P extra input cycles.
- R9: A configuration write takes effect at the next obeyed strobe, or while the divider is idle, or at the end of the current full period. The phases of the running period are not changed.
- R10: On reset, the configuration takes the parameter defaults (timing 0x00 and control 0x80 for the default instance, which is bypass). An instance with defaults timing 0xBB and control 0x00 divides by 24 with 12 cycles high and 12 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; also clocks all internal state |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Shared restart strobe, active high, synchronous to clk_in |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 selects the timing byte, 1 selects the control byte |
| cfg_wdata | input | 8 | Configuration write data |
| div_out | output | 1 | Divided (or bypassed, or forced) channel clock |

## Verification
The assertions assume that `sync` and the write port change only between rising edges of `clk_in`, and that `sync` is held for at least one edge when it is used as a restart. The stimulus drives every input on the falling edge and samples on the falling edge, or one nanosecond after an edge when the bypassed clock is observed. Every waveform comparison starts from a known restart, or from a period boundary that follows from one, so the expected level at each sample is a closed-form function of the fields.

// File: rtl/chan_div.sv
module chan_div #(
  parameter int         FW        = 4,
  parameter logic [7:0] DEF_TIMING = 8'h00,
  parameter logic [7:0] DEF_CTRL   = 8'h80
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       sync,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic       div_out
);
  localparam int TW = 2 * FW;
  localparam int CW = FW + 4;

  logic [TW-1:0] tim_sh, tim_a;
  logic [CW-1:0] ctl_sh, ctl_a;
  logic [FW-1:0] cnt, poff;
  logic          out_q;

  wire [FW-1:0] hi_a  = tim_a[FW-1:0];
  wire [FW-1:0] lo_a  = tim_a[TW-1:FW];
  wire [FW-1:0] ph_sh = ctl_sh[FW-1:0];
  wire          st_sh = ctl_sh[FW];
  wire          st_a  = ctl_a[FW];
  wire          frc_a = ctl_a[FW+1];
  wire          nos_a = ctl_a[FW+2];
  wire          byp_a = ctl_a[FW+3];

  wire          idle    = byp_a | (nos_a & frc_a);
  wire          hold    = sync & ~nos_a & ~idle;
  wire          restart = idle | hold;
  wire          run_en  = ~restart;
  wire [FW-1:0] lim     = out_q ? hi_a : lo_a;
  wire          at_lim  = (poff == '0) && (cnt == lim);
  wire          per_end = run_en && at_lim && (out_q != st_a);

  assign div_out = byp_a ? clk_in : (idle ? 1'b1 : out_q);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      tim_sh <= DEF_TIMING[TW-1:0];
      ctl_sh <= DEF_CTRL[CW-1:0];
      tim_a  <= DEF_TIMING[TW-1:0];
      ctl_a  <= DEF_CTRL[CW-1:0];
      out_q  <= DEF_CTRL[FW];
      poff   <= DEF_CTRL[FW-1:0];
      cnt    <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel) ctl_sh <= cfg_wdata[CW-1:0];
        else         tim_sh <= cfg_wdata[TW-1:0];
      end
      if (restart) begin
        tim_a <= tim_sh;
        ctl_a <= ctl_sh;
        out_q <= st_sh;
        poff  <= ph_sh;
        cnt   <= '0;
      end else if (poff != '0) begin
        poff <= poff - 1'b1;
      end else if (cnt == lim) begin
        cnt <= '0;
        if (per_end) begin
          tim_a <= tim_sh;
          ctl_a <= ctl_sh;
          out_q <= st_sh;
        end else begin
          out_q <= ~out_q;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1 R2
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    run_en |-> cnt <= lim);

  // R5
  hold_lvl_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    hold |=> (out_q == st_a) && (cnt == '0));

  // R8
  offset_wait_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_en && poff != '0) |=> $stable(out_q));

  // R7
  idle_clear_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    idle |=> (cnt == '0));

  // R9
  cfg_stable_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_en && !per_end) |=> ($stable(tim_a) && $stable(ctl_a)));
endmodule

// File: tb/chan_div_tb_top.sv
module chan_div_tb_top;
  logic clk_in = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b1;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic div_out, div2_out;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_in = ~clk_in;

  chan_div dut_i (
    .clk_in(clk_in), .rst_n(rst_n), .sync(sync), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .div_out(div_out));

  chan_div #(.DEF_TIMING(8'hBB), .DEF_CTRL(8'h00)) dut2_i (
    .clk_in(clk_in), .rst_n(rst_n), .sync(1'b0), .cfg_we(1'b0),
    .cfg_sel(1'b0), .cfg_wdata(8'h00), .div_out(div2_out));

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_lvl(input int k, input int h, input int l, input int p, input bit s);
    int t, m, ns;
    t = k - p;
    if (t < 0) return s;
    ns = s ? h + 1 : l + 1;
    m = t % (h + l + 2);
    return (m < ns) ? s : ~s;
  endfunction

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk_in);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk_in);
    cfg_we = 1'b0;
  endtask

  task automatic run_restart(input int h, input int l, input logic [7:0] ctl, input string req);
    int p, n, bad_k, bad_a, bad_e;
    bit s, e;
    p = ctl[3:0]; s = ctl[4];
    n = p + 2 * (h + l + 2) + 1;
    bad_k = -1; bad_a = 0; bad_e = 0;
    sync = 1'b1;
    wr(1'b0, {l[3:0], h[3:0]});
    wr(1'b1, ctl);
    repeat (34) @(negedge clk_in);
    sync = 1'b0;
    for (int k = 0; k < n; k++) begin
      e = exp_lvl(k, h, l, p, s);
      if (div_out !== e && bad_k < 0) begin bad_k = k; bad_a = div_out; bad_e = e; end
      @(negedge clk_in);
    end
    check(bad_k < 0, req, bad_a, bad_e, $sformatf("waveform h=%0d l=%0d ctl=%02h first bad k=%0d", h, l, ctl, bad_k));
  endtask

  task automatic check_follows_clk(input string req, input string what);
    int bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #1; if (div_out !== 1'b1) bad++;
      @(negedge clk_in); #1; if (div_out !== 1'b0) bad++;
    end
    check(bad == 0, req, bad, 0, what);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hc, lc, bad;
    bit e;
    repeat (3) @(negedge clk_in);
    rst_n = 1'b1;
    // R10 default instance comes up in bypass
    check_follows_clk("R10", "reset default bypass");
    // R10 second instance: divide by 24, 12 high 12 low
    while (div2_out !== 1'b0) @(negedge clk_in);
    while (div2_out !== 1'b1) @(negedge clk_in);
    hc = 0; lc = 0;
    while (div2_out === 1'b1 && hc < 100) begin hc++; @(negedge clk_in); end
    while (div2_out === 1'b0 && lc < 100) begin lc++; @(negedge clk_in); end
    check(hc == 12, "R10", hc, 12, "second instance high cycles");
    check(lc == 12, "R10", lc, 12, "second instance low cycles");

    // R1 R2 R3 R5: sweep every high/low combination, start low
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++)
        run_restart(h, l, 8'h00, "R1/R2/R3/R5");

    // R8 R3: phase offset sweep, start high
    for (int p = 0; p < 16; p++)
      run_restart(2, 4, 8'h10 | p[7:0], "R8/R3");

    // R7: force bit without ignore-strobe has no effect
    run_restart(3, 1, 8'h20, "R7");

    // R9: timing write during the high phase waits for period end
    sync = 1'b1;
    wr(1'b0, 8'h33);
    wr(1'b1, 8'h00);
    repeat (34) @(negedge clk_in);
    sync = 1'b0;
    bad = -1;
    for (int k = 0; k < 16; k++) begin
      e = (k < 8) ? exp_lvl(k, 3, 3, 0, 1'b0) : ((k - 8) % 2 == 1);
      if (div_out !== e && bad < 0) bad = k;
      if (k == 5) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h00; end
      if (k == 6) cfg_we = 1'b0;
      @(negedge clk_in);
    end
    check(bad < 0, "R9", bad, -1, "shadow update first bad k");

    // R6: ignore-strobe set mid-run, then strobe pulses with no effect
    sync = 1'b1;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    repeat (34) @(negedge clk_in);
    sync = 1'b0;
    bad = -1;
    for (int k = 0; k < 25; k++) begin
      e = exp_lvl(k, 1, 1, 0, 1'b0);
      if (div_out !== e && bad < 0) bad = k;
      if (k == 2) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h40; end
      if (k == 3) cfg_we = 1'b0;
      if (k == 9) sync = 1'b1;
      if (k == 14) sync = 1'b0;
      @(negedge clk_in);
    end
    check(bad < 0, "R6", bad, -1, "strobe ignored first bad k");

    // R7: force with ignore-strobe holds output high
    wr(1'b1, 8'h60);
    repeat (10) @(negedge clk_in);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_in); #1; if (div_out !== 1'b1) bad++;
      @(negedge clk_in); #1; if (div_out !== 1'b1) bad++;
    end
    check(bad == 0, "R7", bad, 0, "forced high samples not high");
    sync = 1'b1;
    repeat (3) @(negedge clk_in);
    sync = 1'b0;
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk_in); if (div_out !== 1'b1) bad++; end
    check(bad == 0, "R7", bad, 0, "forced high across strobe");

    // R4: bypass overrides force
    wr(1'b1, 8'hE0);
    repeat (3) @(negedge clk_in);
    check_follows_clk("R4", "bypass over force");
    wr(1'b1, 8'h80);
    repeat (3) @(negedge clk_in);
    check_follows_clk("R4", "plain bypass");

    // R5: leave bypass and restart under strobe again
    run_restart(0, 0, 8'h00, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule